// File: doc/BRIEF.md
# External Memory Access Sequencer

The sequencer sits between a processor core and a single shared external memory port. In each instruction cycle the core may raise a request for each of three memory spaces: X data, Y data and program. Each request carries an internal/external flag, a 16-bit address, a 24-bit write word and a write flag. Only requests that are both raised and marked external reach the pins. The block serves them one at a time in a fixed space order, so a dual X/Y or long-word access becomes two bus accesses.

Each access lasts one cycle plus a number of wait states. The count comes from a 4-bit field per space, and an external wait input can stretch the access further. The block holds the core stalled until the last external access of the instruction ends. The core keeps its request inputs steady while stalled and moves on at the clock edge that ends the final access. When no external access is in flight, the strobes stay low and the address and data pins keep their last values, so internal traffic never toggles the bus. Read data from the bus is latched per space and handed to the core on the cycle the access ends.

Top module: `ext_mem_sequencer`

## Requirements
- R1: At most one of `ext_xsel`, `ext_ysel`, `ext_psel` is high in any cycle, and `ext_rd` and `ext_wr` are never high together.
- R2: Pending external accesses of one instruction are served in the order X, then Y, then program. A request counts only when both its request flag and its external flag are set.
- R3: With zero wait states, N pending external accesses take exactly N cycles. `core_stall` is high in every one of those cycles except the last.
- R4: `ws_cfg[3:0]` holds the X wait count, `ws_cfg[7:4]` the Y count and `ws_cfg[11:8]` the program count. An access with count W and `ext_wait` low lasts W+1 cycles.
- R5: `ext_wait` is ignored while wait states remain. Once they are used up, the access ends in the first cycle with `ext_wait` low.
- R6: With no pending external access, all strobes and `core_stall` are low. `ext_addr` and `ext_dout` keep the values of the last external access (zero after reset).
- R7: On a read, `rdata_x`/`rdata_y`/`rdata_p` for the served space take the value on `ext_din` in the final cycle of the access, and keep it afterwards. Writes leave the space's read register unchanged.
- R8: During an access, `ext_addr` carries the space's address. A write drives `ext_wr`, `ext_dout_en` and the write word on `ext_dout`. A read drives `ext_rd`.
- R9: After reset, every strobe, `core_stall`, `ext_addr` and the read registers are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_x | input | 1 | X space request |
| req_y | input | 1 | Y space request |
| req_p | input | 1 | Program space request |
| ext_x | input | 1 | X request targets external memory |
| ext_y | input | 1 | Y request targets external memory |
| ext_p | input | 1 | Program request targets external memory |
| addr_x | input | 16 | X address |
| addr_y | input | 16 | Y address |
| addr_p | input | 16 | Program address |
| wdata_x | input | 24 | X write word |
| wdata_y | input | 24 | Y write word |
| wdata_p | input | 24 | Program write word |
| wr_x | input | 1 | X request is a write |
| wr_y | input | 1 | Y request is a write |
| wr_p | input | 1 | Program request is a write |
| ws_cfg | input | 12 | Wait counts: [3:0] X, [7:4] Y, [11:8] program |
| ext_wait | input | 1 | External request to extend the access |
| ext_din | input | 24 | Read data from the bus |
| ext_addr | output | 16 | Bus address |
| ext_dout | output | 24 | Bus write data |
| ext_dout_en | output | 1 | Drive enable for write data |
| ext_rd | output | 1 | Read strobe |
| ext_wr | output | 1 | Write strobe |
| ext_xsel | output | 1 | X space select |
| ext_ysel | output | 1 | Y space select |
| ext_psel | output | 1 | Program space select |
| core_stall | output | 1 | Core must hold its current instruction |
| rdata_x | output | 24 | Latest X read word |
| rdata_y | output | 24 | Latest Y read word |
| rdata_p | output | 24 | Latest program read word |

## Verification
Strobes, address, stall and read-data bypass depend combinationally on the inputs and the registered progress state. Every result is therefore due in the same cycle the requests are applied, and it advances by one space per finishing access. The bench drives inputs at the falling edge and samples 2 ns later, well before the next rising edge. For each access it predicts the cycle count from the wait field (W+1, or one past the last `ext_wait` cycle once the count is spent), and it checks select, address and stall in every one of those cycles. After the final access it drops the requests and checks, in the next cycle, that the pins are idle and held and that the read registers kept their values.

// File: rtl/ext_mem_sequencer.sv
module ext_mem_sequencer #(
  parameter int AW  = 16,
  parameter int DW  = 24,
  parameter int WSW = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_x,
  input  logic             req_y,
  input  logic             req_p,
  input  logic             ext_x,
  input  logic             ext_y,
  input  logic             ext_p,
  input  logic [AW-1:0]    addr_x,
  input  logic [AW-1:0]    addr_y,
  input  logic [AW-1:0]    addr_p,
  input  logic [DW-1:0]    wdata_x,
  input  logic [DW-1:0]    wdata_y,
  input  logic [DW-1:0]    wdata_p,
  input  logic             wr_x,
  input  logic             wr_y,
  input  logic             wr_p,
  input  logic [3*WSW-1:0] ws_cfg,
  input  logic             ext_wait,
  input  logic [DW-1:0]    ext_din,
  output logic [AW-1:0]    ext_addr,
  output logic [DW-1:0]    ext_dout,
  output logic             ext_dout_en,
  output logic             ext_rd,
  output logic             ext_wr,
  output logic             ext_xsel,
  output logic             ext_ysel,
  output logic             ext_psel,
  output logic             core_stall,
  output logic [DW-1:0]    rdata_x,
  output logic [DW-1:0]    rdata_y,
  output logic [DW-1:0]    rdata_p
);

  logic [2:0]     served;
  logic           busy;
  logic [WSW-1:0] cnt;
  logic [AW-1:0]  hold_addr;
  logic [DW-1:0]  hold_dout;
  logic [DW-1:0]  rx_q, ry_q, rp_q;

  logic [2:0]     need, cur;
  logic           active, last, fin, sel_wr;
  logic [AW-1:0]  sel_addr;
  logic [DW-1:0]  sel_wdata;
  logic [WSW-1:0] field, rem;

  assign need   = {req_p & ext_p, req_y & ext_y, req_x & ext_x} & ~served & {3{~rst}};
  assign cur    = {need[2] & ~|need[1:0], need[1] & ~need[0], need[0]};
  assign active = |need;
  assign last   = (need & ~cur) == 3'b000;

  always_comb begin
    sel_addr  = addr_p;
    sel_wdata = wdata_p;
    sel_wr    = wr_p;
    field     = ws_cfg[2*WSW +: WSW];
    if (cur[0]) begin
      sel_addr = addr_x; sel_wdata = wdata_x; sel_wr = wr_x; field = ws_cfg[0 +: WSW];
    end else if (cur[1]) begin
      sel_addr = addr_y; sel_wdata = wdata_y; sel_wr = wr_y; field = ws_cfg[WSW +: WSW];
    end
  end

  assign rem        = busy ? cnt : field;
  assign fin        = active && (rem == '0) && !ext_wait;
  assign core_stall = active && !(fin && last);

  assign ext_addr    = active ? sel_addr : hold_addr;
  assign ext_dout    = active ? sel_wdata : hold_dout;
  assign ext_rd      = active && !sel_wr;
  assign ext_wr      = active && sel_wr;
  assign ext_dout_en = ext_wr;
  assign {ext_psel, ext_ysel, ext_xsel} = cur;

  assign rdata_x = (fin && cur[0] && !sel_wr) ? ext_din : rx_q;
  assign rdata_y = (fin && cur[1] && !sel_wr) ? ext_din : ry_q;
  assign rdata_p = (fin && cur[2] && !sel_wr) ? ext_din : rp_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      served    <= '0;
      busy      <= 1'b0;
      cnt       <= '0;
      hold_addr <= '0;
      hold_dout <= '0;
      rx_q      <= '0;
      ry_q      <= '0;
      rp_q      <= '0;
    end else if (active) begin
      hold_addr <= sel_addr;
      hold_dout <= sel_wdata;
      rx_q      <= rdata_x;
      ry_q      <= rdata_y;
      rp_q      <= rdata_p;
      if (fin) begin
        busy   <= 1'b0;
        served <= last ? 3'b000 : (served | cur);
      end else begin
        busy <= 1'b1;
        cnt  <= (rem == '0) ? '0 : rem - 1'b1;
      end
    end
  end

endmodule

// File: rtl/ext_mem_sequencer_chk.sv
module ext_mem_sequencer_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          ext_xsel,
  input logic          ext_ysel,
  input logic          ext_psel,
  input logic          ext_rd,
  input logic          ext_wr,
  input logic          ext_dout_en,
  input logic          core_stall,
  input logic          ext_wait,
  input logic [AW-1:0] ext_addr
);

  logic any_sel;
  assign any_sel = ext_xsel | ext_ysel | ext_psel;

  p_one_space_r1: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ext_xsel, ext_ysel, ext_psel}));

  p_rd_wr_excl_r1: assert property (@(posedge clk) disable iff (rst)
    !(ext_rd && ext_wr));

  p_stall_has_access_r3: assert property (@(posedge clk) disable iff (rst)
    core_stall |-> any_sel);

  p_end_needs_wait_low_r5: assert property (@(posedge clk) disable iff (rst)
    (any_sel && !core_stall) |-> !ext_wait);

  p_idle_addr_held_r6: assert property (@(posedge clk) disable iff (rst)
    (!any_sel && !$past(any_sel)) |-> $stable(ext_addr));

  p_idle_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    !any_sel |-> !(ext_rd || ext_wr || core_stall));

  p_write_drives_r8: assert property (@(posedge clk) disable iff (rst)
    ext_wr |-> (ext_dout_en && any_sel));

endmodule

bind ext_mem_sequencer ext_mem_sequencer_chk #(.AW(AW)) i_chk (
  .clk(clk), .rst(rst), .ext_xsel(ext_xsel), .ext_ysel(ext_ysel),
  .ext_psel(ext_psel), .ext_rd(ext_rd), .ext_wr(ext_wr),
  .ext_dout_en(ext_dout_en), .core_stall(core_stall),
  .ext_wait(ext_wait), .ext_addr(ext_addr)
);

// File: tb/test_ext_mem_sequencer.sv
module test_ext_mem_sequencer;
  logic clk = 0, rst = 1;
  logic req_x = 0, req_y = 0, req_p = 0, ext_x = 0, ext_y = 0, ext_p = 0;
  logic [15:0] addr_x = 0, addr_y = 0, addr_p = 0;
  logic [23:0] wdata_x = 0, wdata_y = 0, wdata_p = 0;
  logic wr_x = 0, wr_y = 0, wr_p = 0;
  logic [11:0] ws_cfg = 0;
  logic ext_wait = 0;
  logic [23:0] ext_din = 0;
  logic [15:0] ext_addr;
  logic [23:0] ext_dout, rdata_x, rdata_y, rdata_p;
  logic ext_dout_en, ext_rd, ext_wr, ext_xsel, ext_ysel, ext_psel, core_stall;

  int checks = 0, failures = 0;
  bit finished = 0;
  logic [15:0] m_addr = 0;
  logic [23:0] m_dout = 0;
  logic [23:0] m_rd [3];

  always #5 clk = ~clk;

  ext_mem_sequencer i_ext_mem_sequencer (.*);

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [2:0] sels();
    return {ext_psel, ext_ysel, ext_xsel};
  endfunction

  task automatic check_idle(string req);
    chk(req, "idle selects", {29'd0, sels()}, 32'd0);
    chk(req, "idle stall", {31'd0, core_stall}, 32'd0);
    chk(req, "idle rd/wr", {30'd0, ext_rd, ext_wr}, 32'd0);
    chk(req, "held addr", {16'd0, ext_addr}, {16'd0, m_addr});
    chk(req, "held dout", {8'd0, ext_dout}, {8'd0, m_dout});
  endtask

  task automatic check_rdata(string req);
    chk(req, "rdata_x", {8'd0, rdata_x}, {8'd0, m_rd[0]});
    chk(req, "rdata_y", {8'd0, rdata_y}, {8'd0, m_rd[1]});
    chk(req, "rdata_p", {8'd0, rdata_p}, {8'd0, m_rd[2]});
  endtask

  task automatic run(input logic [2:0] rq, input logic [2:0] ex,
                     input logic [2:0] wm, input logic [11:0] ws, input int t);
    logic [2:0] act;
    int lasts;
    logic [15:0] ad [3];
    logic [23:0] wd [3];
    act = rq & ex;
    lasts = -1;
    for (int s = 0; s < 3; s++) begin
      ad[s] = 16'h1000 * (s + 1) + 16'(t);
      wd[s] = 24'h100000 * (s + 1) + 24'(t * 7);
      if (act[s]) lasts = s;
    end
    {req_p, req_y, req_x} = rq;
    {ext_p, ext_y, ext_x} = ex;
    {wr_p, wr_y, wr_x} = wm;
    addr_x = ad[0]; addr_y = ad[1]; addr_p = ad[2];
    wdata_x = wd[0]; wdata_y = wd[1]; wdata_p = wd[2];
    ws_cfg = ws;
    if (lasts < 0) begin
      #2 check_idle("R6");
      @(negedge clk);
    end else begin
      for (int s = 0; s < 3; s++) begin
        if (act[s]) begin
          int dur;
          dur = int'(ws[4*s +: 4]) + 1;
          ext_din = 24'hD00000 + 24'(ad[s]);
          for (int c = 0; c < dur; c++) begin
            #2;
            chk("R2", "select order", {29'd0, sels()}, 32'd1 << s);
            chk("R8", "bus addr", {16'd0, ext_addr}, {16'd0, ad[s]});
            chk("R8", "write strobe", {30'd0, ext_wr, ext_rd}, wm[s] ? 32'd2 : 32'd1);
            if (wm[s]) chk("R8", "write data", {8'd0, ext_dout}, {8'd0, wd[s]});
            if (ws == 12'h000)
              chk("R3", "stall zero-wait", {31'd0, core_stall}, {31'd0, (s != lasts)});
            else
              chk("R4", "stall with waits", {31'd0, core_stall},
                  {31'd0, !((s == lasts) && (c == dur - 1))});
            @(negedge clk);
          end
          m_addr = ad[s];
          m_dout = wd[s];
          if (!wm[s]) m_rd[s] = 24'hD00000 + 24'(ad[s]);
        end
      end
    end
    req_x = 0; req_y = 0; req_p = 0;
    #2 check_idle("R6");
    check_rdata("R7");
    @(negedge clk);
  endtask

  task automatic wait_case(input logic [3:0] f, input int w, input int t);
    int dur;
    dur = ((w > int'(f)) ? w : int'(f)) + 1;
    {req_p, req_y, req_x} = 3'b001;
    {ext_p, ext_y, ext_x} = 3'b111;
    wr_x = 0;
    addr_x = 16'hA000 + 16'(t);
    ws_cfg = {8'h00, f};
    ext_din = 24'hE00000 + 24'(t);
    for (int c = 0; c < dur; c++) begin
      ext_wait = (c < w);
      #2;
      chk("R5", "x select held", {31'd0, ext_xsel}, 32'd1);
      chk("R5", "stall during wait", {31'd0, core_stall}, {31'd0, (c != dur - 1)});
      @(negedge clk);
    end
    m_addr = addr_x;
    m_dout = wdata_x;
    m_rd[0] = 24'hE00000 + 24'(t);
    ext_wait = 1;
    req_x = 0;
    #2 check_idle("R5");
    check_rdata("R5");
    ext_wait = 0;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    if (!finished) begin
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int t;
    m_rd[0] = 0; m_rd[1] = 0; m_rd[2] = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    #2;
    chk("R9", "reset selects", {29'd0, sels()}, 32'd0);
    chk("R9", "reset stall", {31'd0, core_stall}, 32'd0);
    chk("R9", "reset addr", {16'd0, ext_addr}, 32'd0);
    check_rdata("R9");
    @(negedge clk);
    t = 0;
    for (int wsi = 0; wsi < 2; wsi++)
      for (int wmi = 0; wmi < 3; wmi++)
        for (int rq = 0; rq < 8; rq++)
          for (int ex = 0; ex < 8; ex++) begin
            logic [2:0] wm;
            wm = (wmi == 0) ? 3'b000 : (wmi == 1) ? 3'b111 : 3'b010;
            run(3'(rq), 3'(ex), wm, (wsi == 0) ? 12'h000 : 12'h5A3, t);
            t++;
          end
    wait_case(4'd2, 5, 1);
    wait_case(4'd3, 2, 2);
    wait_case(4'd0, 0, 3);
    wait_case(4'd15, 0, 4);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule